// File: doc/BRIEF.md
# Two-Entry Receive Character Buffer with Overrun Lock

This block sits between a serial receive engine and a register-read interface. Each time the engine finishes a 9-bit character it presents it for one cycle. The buffer keeps up to two such characters. The oldest unread character is shown at the outputs as a low byte plus a separate ninth bit. A single read strobe on the low byte retires that character and brings the next one forward. A data-available flag is high while any character is still unread.

When a third complete character arrives while both entries are occupied and no read retires one, the block raises an overrun flag. It drops the new character and keeps the two stored ones intact and readable. While the flag is up the block refuses every further character. The receive mode in force at the moment of overrun is latched, and that mode decides how the lock is released. After an overrun in single-receive mode, a read strobe releases it. After an overrun in continuous mode, only dropping the continuous enable or dropping the port enable releases it. Dropping the port enable also empties the buffer.

Top module: `rx_char_buffer`

## Requirements
- R1: After reset `data_avail` and `overrun` are both 0.
- R2: Accepted characters leave in arrival order. `top_low` carries bits [7:0] of the oldest unread character and `top_bit9` carries its bit 8. A read strobe retires that character at the next clock edge.
- R3: `data_avail` is 1 from the edge that accepts a character into an empty buffer until the edge that retires the last unread one.
- R4: If a character is offered while both entries are full, no read strobe is given and no overrun is pending, then `overrun` rises at that edge and the character is dropped. The two stored characters stay unchanged and are read out in order.
- R5: While `overrun` is 1, offered characters are discarded.
- R6: If the overrun was raised while `cont_en` was 0, a read strobe clears `overrun` at the same edge that retires a character. Characters are accepted again after that edge.
- R7: If the overrun was raised while `cont_en` was 1, read strobes still retire characters but leave `overrun` set. Driving `cont_en` to 0 clears it at the next edge.
- R8: The mode used for clearing is the `cont_en` value at the overrun edge. Raising `cont_en` afterwards does not stop a read strobe from clearing a single-mode overrun.
- R9: With `port_en` at 0, the buffer empties and `overrun` clears at the next edge, and offered characters are discarded.
- R10: A character offered together with a read strobe on a full buffer is accepted without raising `overrun`, and order is kept.
- R11: A read strobe on an empty buffer changes nothing. `data_avail` stays 0, and the next character is presented correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Port enable; 0 flushes and releases the lock |
| cont_en | input | 1 | 1 = continuous receive, 0 = single receive |
| push_valid | input | 1 | One-cycle strobe: a complete character is offered |
| push_char | input | 9 | Offered character, bit 8 is the ninth bit |
| rd_strobe | input | 1 | Read of the low byte; retires the top character |
| top_low | output | 8 | Bits [7:0] of the oldest unread character |
| top_bit9 | output | 1 | Bit 8 of the oldest unread character |
| data_avail | output | 1 | At least one unread character is stored |
| overrun | output | 1 | Overrun lock is set |

## Verification
All outputs come straight from registers. The effect of any input sampled at a rising edge is therefore visible one cycle later and is stable until the following edge. The bench applies each stimulus just after an edge and checks the outputs one nanosecond after the next edge, so every check lands exactly one register stage behind its cause. Release of the overrun lock, whether by a read, by `cont_en` or by `port_en`, is checked in that same cycle. The top character is compared only while `data_avail` is 1.

// File: rtl/rx_char_buffer_pkg.sv
package rx_char_buffer_pkg;

    typedef enum logic {
        RXM_SINGLE = 1'b0,
        RXM_CONT   = 1'b1
    } rx_mode_e;

    typedef struct packed {
        logic     locked;
        rx_mode_e mode;
    } lock_state_t;

endpackage

// File: rtl/rx_char_store.sv
module rx_char_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic                              wr_en,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              rd_en,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]        fill,
    output logic                              full,
    output logic                              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } store_t;

    store_t st_d, st_q;
    logic [DEPTH-1:0] slot_we;

    // per-entry write select
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign slot_we[g] = wr_en && (st_q.wr_ptr == PTR_W'(g));
    end

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) begin
                st_d.mem[i] = wr_data;
            end
        end
        if (wr_en) begin
            st_d.wr_ptr = bump(st_q.wr_ptr);
        end
        if (rd_en) begin
            st_d.rd_ptr = bump(st_q.rd_ptr);
        end
        case ({wr_en, rd_en})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.cnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[st_q.rd_ptr];
    assign fill    = st_q.cnt;
    assign full    = (st_q.cnt == FULL_CNT);
    assign empty   = (st_q.cnt == '0);

endmodule

// File: rtl/rx_overrun_lock.sv
module rx_overrun_lock
    import rx_char_buffer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic cont_en,
    input  logic ovf_event,
    input  logic rd_strobe,
    output logic locked,
    output logic locked_cont
);
    lock_state_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (!port_en) begin
            lk_d.locked = 1'b0;
            lk_d.mode   = RXM_SINGLE;
        end else if (lk_q.locked) begin
            // release rule follows the mode latched at overrun time
            if (lk_q.mode == RXM_SINGLE) begin
                if (rd_strobe) begin
                    lk_d.locked = 1'b0;
                end
            end else if (!cont_en) begin
                lk_d.locked = 1'b0;
            end
        end else if (ovf_event) begin
            lk_d.locked = 1'b1;
            lk_d.mode   = cont_en ? RXM_CONT : RXM_SINGLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_q <= '{locked: 1'b0, mode: RXM_SINGLE};
        end else begin
            lk_q <= lk_d;
        end
    end

    assign locked      = lk_q.locked;
    assign locked_cont = (lk_q.mode == RXM_CONT);

endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_en,
    input  logic              cont_en,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_char,
    input  logic              rd_strobe,
    output logic [DATA_W-2:0] top_low,
    output logic              top_bit9,
    output logic              data_avail,
    output logic              overrun
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              pop;
    logic              accept;
    logic              ovf_event;
    logic              full;
    logic              empty;
    logic              locked;
    logic              locked_cont;
    logic [CNT_W-1:0]  fill;
    logic [DATA_W-1:0] top_char;

    assign pop       = port_en && rd_strobe && !empty;
    assign accept    = port_en && push_valid && !locked && (!full || pop);
    assign ovf_event = port_en && push_valid && !locked && full && !pop;

    rx_char_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!port_en),
        .wr_en   (accept),
        .wr_data (push_char),
        .rd_en   (pop),
        .rd_data (top_char),
        .fill    (fill),
        .full    (full),
        .empty   (empty)
    );

    rx_overrun_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_en     (port_en),
        .cont_en     (cont_en),
        .ovf_event   (ovf_event),
        .rd_strobe   (rd_strobe),
        .locked      (locked),
        .locked_cont (locked_cont)
    );

    assign top_low    = top_char[DATA_W-2:0];
    assign top_bit9   = top_char[DATA_W-1];
    assign data_avail = !empty;
    assign overrun    = locked;

endmodule

// File: rtl/rx_char_buffer_chk.sv
module rx_char_buffer_chk #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       port_en,
    input logic                       cont_en,
    input logic                       push_valid,
    input logic                       rd_strobe,
    input logic [DATA_W-2:0]          top_low,
    input logic                       top_bit9,
    input logic                       data_avail,
    input logic                       overrun,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       full,
    input logic                       locked_cont
);
    a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && !overrun && push_valid && full && !rd_strobe |=> overrun);

    a_r4_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && overrun && !rd_strobe |=>
            (top_low == $past(top_low)) && (top_bit9 == $past(top_bit9)));

    a_r5_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && overrun && push_valid && !rd_strobe |=> fill == $past(fill));

    a_r6_single_release: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && overrun && !locked_cont && rd_strobe |=> !overrun);

    a_r7_cont_hold: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && overrun && locked_cont && cont_en |=> overrun);

    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> !data_avail && !overrun);

    a_r10_swap: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && full && push_valid && rd_strobe && !overrun |=> !overrun && full);

    a_r3_avail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        port_en && data_avail && !rd_strobe |=> data_avail);

endmodule

bind rx_char_buffer rx_char_buffer_chk #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .port_en     (port_en),
    .cont_en     (cont_en),
    .push_valid  (push_valid),
    .rd_strobe   (rd_strobe),
    .top_low     (top_low),
    .top_bit9    (top_bit9),
    .data_avail  (data_avail),
    .overrun     (overrun),
    .fill        (fill),
    .full        (full),
    .locked_cont (locked_cont)
);

// File: tb/rx_char_buffer_test.sv
`timescale 1ns/1ps
module rx_char_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b0;
    logic       cont_en = 1'b0;
    logic       push_valid = 1'b0;
    logic [8:0] push_char = '0;
    logic       rd_strobe = 1'b0;
    logic [7:0] top_low;
    logic       top_bit9;
    logic       data_avail;
    logic       overrun;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rx_char_buffer uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_en    (port_en),
        .cont_en    (cont_en),
        .push_valid (push_valid),
        .push_char  (push_char),
        .rd_strobe  (rd_strobe),
        .top_low    (top_low),
        .top_bit9   (top_bit9),
        .data_avail (data_avail),
        .overrun    (overrun)
    );

    // vector: push_valid, char[8:0], rd, exp_avail, exp_ovr, exp_char[8:0]
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 9'h1A5, 1'b0, 1'b1, 1'b0, 9'h1A5},
        {1'b1, 9'h03C, 1'b0, 1'b1, 1'b0, 9'h1A5},
        {1'b1, 9'h0FF, 1'b0, 1'b1, 1'b1, 9'h1A5},
        {1'b1, 9'h111, 1'b0, 1'b1, 1'b1, 9'h1A5},
        {1'b0, 9'h000, 1'b1, 1'b1, 1'b0, 9'h03C},
        {1'b1, 9'h122, 1'b1, 1'b1, 1'b0, 9'h122},
        {1'b1, 9'h044, 1'b0, 1'b1, 1'b0, 9'h122},
        {1'b1, 9'h155, 1'b1, 1'b1, 1'b0, 9'h044},
        {1'b0, 9'h000, 1'b1, 1'b1, 1'b0, 9'h155},
        {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 9'h000},
        {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 9'h000},
        {1'b1, 9'h0AB, 1'b0, 1'b1, 1'b0, 9'h0AB},
        {1'b0, 9'h000, 1'b1, 1'b0, 1'b0, 9'h000}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:    return "R2 R3 push";
            2:       return "R4 third char sets overrun";
            3:       return "R5 push ignored while overrun";
            4:       return "R6 R4 single-mode read clears, order kept";
            5:       return "R6 accepted again after release";
            6:       return "R2 refill";
            7:       return "R10 push+read on full";
            8, 9:    return "R3 drain";
            10:      return "R11 read on empty";
            11:      return "R11 push after empty read";
            default: return "R3 final drain";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_state(input string tag, input bit ea, input bit eo,
                                input logic [8:0] ec);
        chk({tag, " data_avail"}, int'(data_avail), int'(ea));
        chk({tag, " overrun"}, int'(overrun), int'(eo));
        if (ea) begin
            chk({tag, " top char"}, int'({top_bit9, top_low}), int'(ec));
        end
    endtask

    task automatic step(input bit pv, input logic [8:0] d, input bit rd);
        push_valid = pv;
        push_char  = d;
        rd_strobe  = rd;
        @(posedge clk);
        #1;
        push_valid = 1'b0;
        rd_strobe  = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 data_avail at reset", int'(data_avail), 0);
        chk("R1 overrun at reset", int'(overrun), 0);
        rst_n = 1'b1;
        port_en = 1'b1;
        @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][21], VEC[i][20:12], VEC[i][11]);
            expect_state(vec_tag(i), VEC[i][10], VEC[i][9], VEC[i][8:0]);
        end

        // R7: continuous-mode overrun
        cont_en = 1'b1;
        step(1'b1, 9'h101, 1'b0);
        step(1'b1, 9'h002, 1'b0);
        step(1'b1, 9'h1F0, 1'b0);
        expect_state("R4 cont overrun set", 1'b1, 1'b1, 9'h101);
        step(1'b0, 9'h000, 1'b1);
        expect_state("R7 read keeps cont overrun", 1'b1, 1'b1, 9'h002);
        step(1'b1, 9'h0EE, 1'b0);
        expect_state("R5 cont push ignored", 1'b1, 1'b1, 9'h002);
        cont_en = 1'b0;
        step(1'b0, 9'h000, 1'b0);
        expect_state("R7 cont_en low clears", 1'b1, 1'b0, 9'h002);
        step(1'b0, 9'h000, 1'b1);
        expect_state("R5 dropped char absent", 1'b0, 1'b0, 9'h000);

        // R8: single-mode overrun, then cont_en raised
        step(1'b1, 9'h010, 1'b0);
        step(1'b1, 9'h020, 1'b0);
        step(1'b1, 9'h030, 1'b0);
        cont_en = 1'b1;
        step(1'b0, 9'h000, 1'b0);
        expect_state("R8 lock held before read", 1'b1, 1'b1, 9'h010);
        step(1'b0, 9'h000, 1'b1);
        expect_state("R8 latched single mode, read clears", 1'b1, 1'b0, 9'h020);
        step(1'b0, 9'h000, 1'b1);
        expect_state("R8 drain", 1'b0, 1'b0, 9'h000);
        cont_en = 1'b0;

        // R9: port enable low flushes
        step(1'b1, 9'h0A1, 1'b0);
        step(1'b1, 9'h0A2, 1'b0);
        step(1'b1, 9'h0A3, 1'b0);
        expect_state("R9 precondition overrun", 1'b1, 1'b1, 9'h0A1);
        port_en = 1'b0;
        step(1'b0, 9'h000, 1'b0);
        expect_state("R9 flush", 1'b0, 1'b0, 9'h000);
        step(1'b1, 9'h0A4, 1'b0);
        expect_state("R9 push ignored while disabled", 1'b0, 1'b0, 9'h000);
        port_en = 1'b1;
        step(1'b1, 9'h1A5, 1'b0);
        expect_state("R9 fresh after enable", 1'b1, 1'b0, 9'h1A5);
        step(1'b0, 9'h000, 1'b1);
        expect_state("R9 single char drained", 1'b0, 1'b0, 9'h000);

        finish_run();
    end
endmodule